// File: doc/BRIEF.md
# Key-Protected Clock Source Configuration Register

This block holds the small register that picks the clock source for the rest of the chip. Software cannot change it with a single store. A new value is accepted only inside a three-step unlock ritual on a plain memory-mapped register bus. The ritual has three parts, and they must be consecutive bus writes:

1. a write of the first key value to the first key address;
2. the write of the new value to the configuration address;
3. a write of the second key value to the second key address.

Any other write breaks the ritual and throws away the value being held. Reads and idle cycles do not break it.

The committed value drives the clock multiplexing logic through registered outputs: an external-clock enable, a two-bit oscillator select, and a decoded flag that marks when the external crystal is chosen. A sticky error flag records any attempt to write the configuration address outside a valid ritual. Software reads that flag from a status address, and the read clears it.

Top module: `clkcfg_keyreg`

## Requirements
- R1: After synchronous reset the configuration value is 0x00. `ext_clk_en`, `osc_sel` and `xtal_sel` are all 0, and the error flag is 0.
- R2: The sequence commits the low 8 bits of the configuration write, and `ext_clk_en`, `osc_sel` and `xtal_sel` show the new value at the clock edge that samples the second-key write. The sequence is: 0xAA to byte offset 0x410, then the new value to 0x414, then 0x55 to 0x418, on three consecutive bus writes. Before that edge the outputs keep the old value.
- R3: A write to any other address between the steps cancels the sequence, and the held value is discarded. This includes the status address 0x41C, and a second-key write that arrives without a held value. The configuration value does not change.
- R4: A key write with the wrong value cancels the sequence, and the configuration value does not change. Key values are compared over the full 32-bit write data.
- R5: On commit, bits 7:3 of the configuration value are forced to 0.
- R6: `ext_clk_en` equals configuration bit 2 and `osc_sel` equals bits 1:0. `xtal_sel` is 1 only for select code 2'b10. Codes 00, 01 and 11 select the internal 32,768 Hz oscillator.
- R7: A read returns data on `bus_rdata` with `bus_rvalid` high one cycle after `bus_rd`. Offset 0x414 returns the configuration value, zero-extended. Both key offsets read as 0.
- R8: Reads and idle cycles placed between the sequence steps do not change the sequence progress.
- R9: A write to 0x414 that does not immediately follow a valid first-key write sets the error flag. A read of 0x41C returns the flag in bit 0 and clears it. If a set and a clear happen in the same cycle, the set wins.
- R10: A correct first-key write restarts the sequence from any state, and it discards any value already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| ext_clk_en | output | 1 | External clock input enable |
| osc_sel | output | 2 | Oscillator select code |
| xtal_sel | output | 1 | High when the external crystal is selected |

## Verification
The embedded assertions check the following on every cycle:
- the configuration and its outputs move only on a commit, and they take the held value;
- the sequencer never stays in the data-held state across a write;
- non-write cycles leave the sequencer untouched;
- a correct first-key write always lands in the armed state;
- the status read clears the error flag;
- the crystal flag agrees with the select code.

Only the bench scenarios can show that whole write sequences end as they should. These include an interruption by a foreign write, a wrong first or second key, a restart, reads and idle cycles interleaved between steps, and reserved-bit masking. They also show the values software reads back through the bus.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_ARMED     = 2'd1,
    SEQ_HELD      = 2'd2
  } seq_state_t;
endpackage

// File: rtl/clkcfg_decode.sv
module clkcfg_decode #(
  parameter int ADDR_W = 12,
  parameter int unsigned KEY1_OFS = 'h410,
  parameter int unsigned CFG_OFS  = 'h414,
  parameter int unsigned KEY2_OFS = 'h418,
  parameter int unsigned STAT_OFS = 'h41C
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_key1,
  output logic              hit_cfg,
  output logic              hit_key2,
  output logic              hit_stat
);
  always_comb begin
    hit_key1 = (addr == ADDR_W'(KEY1_OFS));
    hit_cfg  = (addr == ADDR_W'(CFG_OFS));
    hit_key2 = (addr == ADDR_W'(KEY2_OFS));
    hit_stat = (addr == ADDR_W'(STAT_OFS));
  end
endmodule

// File: rtl/clkcfg_unlock_seq.sv
module clkcfg_unlock_seq
  import clkcfg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CFG_W  = 8,
  parameter int unsigned KEY1_VAL = 'hAA,
  parameter int unsigned KEY2_VAL = 'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit_key1,
  input  logic              hit_cfg,
  input  logic              hit_key2,
  output logic [CFG_W-1:0]  held_q,
  output logic              commit,
  output logic              cfg_wr_bad
);
  localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY1_VAL);
  localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY2_VAL);

  seq_state_t state_q, state_d;
  logic key1_good, key2_good, cfg_take;

  always_comb begin
    key1_good  = wr_en && hit_key1 && (wdata == K1);
    key2_good  = wr_en && hit_key2 && (wdata == K2);
    cfg_take   = wr_en && hit_cfg && (state_q == SEQ_ARMED);
    commit     = key2_good && (state_q == SEQ_HELD);
    cfg_wr_bad = wr_en && hit_cfg && (state_q != SEQ_ARMED);
  end

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      if (key1_good)     state_d = SEQ_ARMED;
      else if (cfg_take) state_d = SEQ_HELD;
      else               state_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      held_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cfg_take)
        held_q <= wdata[CFG_W-1:0];
      else if (wr_en)
        held_q <= '0;
    end
  end

  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(state_q));
  // R3
  held_no_linger_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && state_q == SEQ_HELD) |=> (state_q != SEQ_HELD));
  // R10
  key1_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_key1 && wdata == K1) |=> (state_q == SEQ_ARMED));
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs #(
  parameter int DATA_W  = 32,
  parameter int CFG_W   = 8,
  parameter int EXT_BIT = 2,
  parameter int SEL_W   = 2,
  parameter int unsigned XTAL_CODE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              hit_cfg,
  input  logic              hit_stat,
  input  logic              commit,
  input  logic              cfg_wr_bad,
  input  logic [CFG_W-1:0]  held,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              ext_clk_en,
  output logic [SEL_W-1:0]  osc_sel,
  output logic              xtal_sel
);
  localparam int LIVE_W = EXT_BIT + 1;
  localparam logic [CFG_W-1:0] KEEP = CFG_W'((1 << LIVE_W) - 1);
  localparam logic [SEL_W-1:0] XC   = SEL_W'(XTAL_CODE);

  logic [CFG_W-1:0] cfg_q, cfg_new;
  logic             err_q;

  assign cfg_new = held & KEEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      ext_clk_en <= 1'b0;
      osc_sel    <= '0;
      xtal_sel   <= 1'b0;
    end else if (commit) begin
      cfg_q      <= cfg_new;
      ext_clk_en <= cfg_new[EXT_BIT];
      osc_sel    <= cfg_new[SEL_W-1:0];
      xtal_sel   <= (cfg_new[SEL_W-1:0] == XC);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    err_q <= 1'b0;
    else if (cfg_wr_bad)        err_q <= 1'b1;
    else if (rd_en && hit_stat) err_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        if (hit_cfg)       rdata <= DATA_W'(cfg_q);
        else if (hit_stat) rdata <= DATA_W'(err_q);
        else               rdata <= '0;
      end
    end
  end

  // R2
  commit_upd_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (cfg_q == ($past(held) & KEEP)));
  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(cfg_q) && $stable(osc_sel) && $stable(ext_clk_en));
  // R6
  xtal_map_chk: assert property (@(posedge clk) disable iff (rst)
    xtal_sel == (osc_sel == XC));
  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && hit_stat && !cfg_wr_bad) |=> !err_q);
  // R7
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);
endmodule

// File: rtl/clkcfg_keyreg.sv
module clkcfg_keyreg #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int CFG_W   = 8,
  parameter int EXT_BIT = 2,
  parameter int SEL_W   = 2,
  parameter int unsigned KEY1_OFS  = 'h410,
  parameter int unsigned CFG_OFS   = 'h414,
  parameter int unsigned KEY2_OFS  = 'h418,
  parameter int unsigned STAT_OFS  = 'h41C,
  parameter int unsigned KEY1_VAL  = 'hAA,
  parameter int unsigned KEY2_VAL  = 'h55,
  parameter int unsigned XTAL_CODE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              ext_clk_en,
  output logic [SEL_W-1:0]  osc_sel,
  output logic              xtal_sel
);
  logic hit_key1, hit_cfg, hit_key2, hit_stat;
  logic commit, cfg_wr_bad;
  logic [CFG_W-1:0] held;

  clkcfg_decode #(
    .ADDR_W(ADDR_W), .KEY1_OFS(KEY1_OFS), .CFG_OFS(CFG_OFS),
    .KEY2_OFS(KEY2_OFS), .STAT_OFS(STAT_OFS)
  ) u_dec (
    .addr(bus_addr), .hit_key1(hit_key1), .hit_cfg(hit_cfg),
    .hit_key2(hit_key2), .hit_stat(hit_stat)
  );

  clkcfg_unlock_seq #(
    .DATA_W(DATA_W), .CFG_W(CFG_W), .KEY1_VAL(KEY1_VAL), .KEY2_VAL(KEY2_VAL)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .wdata(bus_wdata),
    .hit_key1(hit_key1), .hit_cfg(hit_cfg), .hit_key2(hit_key2),
    .held_q(held), .commit(commit), .cfg_wr_bad(cfg_wr_bad)
  );

  clkcfg_regs #(
    .DATA_W(DATA_W), .CFG_W(CFG_W), .EXT_BIT(EXT_BIT), .SEL_W(SEL_W),
    .XTAL_CODE(XTAL_CODE)
  ) u_regs (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .hit_cfg(hit_cfg),
    .hit_stat(hit_stat), .commit(commit), .cfg_wr_bad(cfg_wr_bad),
    .held(held), .rdata(bus_rdata), .rvalid(bus_rvalid),
    .ext_clk_en(ext_clk_en), .osc_sel(osc_sel), .xtal_sel(xtal_sel)
  );
endmodule

// File: tb/tb_clkcfg_keyreg.sv
module tb_clkcfg_keyreg;
  localparam logic [11:0] A_K1 = 12'h410, A_CFG = 12'h414,
                          A_K2 = 12'h418, A_ST = 12'h41C;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, ext_clk_en, xtal_sel;
  logic [1:0] osc_sel;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  clkcfg_keyreg dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ext_clk_en(ext_clk_en), .osc_sel(osc_sel),
    .xtal_sel(xtal_sel)
  );

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_out(input string tag, input logic e, input logic [1:0] s, input logic x);
    checks++;
    if (ext_clk_en !== e || osc_sel !== s || xtal_sel !== x) begin
      errors++;
      $display("FAIL %s outputs: ext=%b sel=%b xtal=%b expected ext=%b sel=%b xtal=%b",
               tag, ext_clk_en, osc_sel, xtal_sel, e, s, x);
    end
  endtask

  task automatic unlock(input logic [31:0] v);
    bus_write(A_K1, 32'hAA);
    bus_write(A_CFG, v);
    bus_write(A_K2, 32'h55);
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected read data: actual=%h expected=none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s read: actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_out("R1", 1'b0, 2'b00, 1'b0);
    bus_read(A_CFG, 32'h0, "R1");
    bus_read(A_ST, 32'h0, "R1");

    // R2 full sequence, outputs change only at second key
    bus_write(A_K1, 32'hAA);
    bus_write(A_CFG, 32'h06);
    chk_out("R2", 1'b0, 2'b00, 1'b0);
    bus_write(A_K2, 32'h55);
    chk_out("R2", 1'b1, 2'b10, 1'b1);
    bus_read(A_CFG, 32'h06, "R7");

    // R5 reserved bits forced zero, R6 internal oscillator code
    unlock(32'hF9);
    chk_out("R5", 1'b0, 2'b01, 1'b0);
    bus_read(A_CFG, 32'h01, "R5");

    // R3 foreign write between steps
    bus_write(A_K1, 32'hAA);
    bus_write(A_CFG, 32'h07);
    bus_write(A_ST, 32'h0);
    bus_write(A_K2, 32'h55);
    chk_out("R3", 1'b0, 2'b01, 1'b0);
    bus_read(A_CFG, 32'h01, "R3");
    // R3 first key then second key with nothing held
    bus_write(A_K1, 32'hAA);
    bus_write(A_K2, 32'h55);
    bus_read(A_CFG, 32'h01, "R3");
    bus_read(A_ST, 32'h0, "R3");

    // R4 wrong first key (also an out-of-sequence config write)
    bus_write(A_K1, 32'hAB);
    bus_write(A_CFG, 32'h07);
    bus_write(A_K2, 32'h55);
    chk_out("R4", 1'b0, 2'b01, 1'b0);
    bus_read(A_ST, 32'h1, "R9");
    bus_read(A_ST, 32'h0, "R9");
    // R4 wrong second key, and a key with upper bits set
    bus_write(A_K1, 32'hAA);
    bus_write(A_CFG, 32'h07);
    bus_write(A_K2, 32'h56);
    bus_write(A_K1, 32'h100AA);
    bus_write(A_CFG, 32'h07);
    bus_write(A_K2, 32'h55);
    chk_out("R4", 1'b0, 2'b01, 1'b0);
    bus_read(A_CFG, 32'h01, "R4");
    bus_read(A_ST, 32'h1, "R9");

    // R8 reads and idle cycles between steps
    bus_write(A_K1, 32'hAA);
    bus_read(A_K1, 32'h0, "R7");
    idle(2);
    bus_write(A_CFG, 32'h04);
    bus_read(A_K2, 32'h0, "R7");
    bus_read(A_CFG, 32'h01, "R8");
    idle(1);
    bus_write(A_K2, 32'h55);
    chk_out("R8", 1'b1, 2'b00, 1'b0);
    bus_read(A_CFG, 32'h04, "R8");

    // R10 restart discards held value
    bus_write(A_K1, 32'hAA);
    bus_write(A_CFG, 32'h02);
    bus_write(A_K1, 32'hAA);
    bus_write(A_CFG, 32'h03);
    bus_write(A_K2, 32'h55);
    chk_out("R10", 1'b0, 2'b11, 1'b0);
    bus_read(A_CFG, 32'h03, "R10");

    // R9 bare config write in idle sets error, read clears
    bus_write(A_CFG, 32'h06);
    chk_out("R9", 1'b0, 2'b11, 1'b0);
    bus_read(A_ST, 32'h1, "R9");
    bus_read(A_ST, 32'h0, "R9");

    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 pending reads: actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule